// File: doc/BRIEF.md
# Gain-State DC Offset Trimmer

This block removes the DC component from a stream of paired in-phase and quadrature baseband samples. It keeps a separate I and Q offset estimate for each front-end gain state. The correction for the selected state is applied to every sample. When the gain index moves, the stored offsets for the new index apply from that very sample. There is no re-learning from zero.

Estimates are refined slowly in the background. Learning samples are gathered into short blocks, and each block mean moves the stored estimate by a leaky first-order step whose strength is a programmable shift. Learning stops as soon as a gain-switch strobe arrives, so switching transients are never taken in. It restarts only after a programmable number of valid samples has passed. A status output tells downstream logic whether the correction is being refined or held. Each state records the temperature tag and gain index seen at its last update. A drift monitor reports how far the active offset moved over a fixed number of updates and raises an alarm against a threshold.

Top module: `dc_offset_trim`

## Requirements
- R1: After a synchronous active-low reset, every stored offset, tag, drift value and output is zero, `out_valid` and `drift_alarm` are low, and `settled` is high.
- R2: One cycle after a sample with `in_valid` high, `out_valid` is high and `out_i`/`out_q` equal the input minus the offset of the `gain_sel` value seen with that sample. `out_valid` is low one cycle after `in_valid` is low.
- R3: The corrected output saturates at 32767 and -32768 instead of wrapping.
- R4: Offsets are held per gain state (8 states). `off_i`/`off_q` always show the entry of the current `gain_sel`, and learning in one state leaves the other states unchanged.
- R5: Learning samples are counted in blocks of 4. On the 4th sample, mean = floor(sum/4) and the 32-bit accumulator (16 fraction bits) becomes acc + ((mean·2^16 − acc) >>> k). The offset is floor(acc/2^16). `shift_k` is clamped to 4..16. A change of `gain_sel`, a strobe, or a cycle with `settled` low discards the partial block.
- R6: A `gain_switch` strobe drives `settled` low on the next cycle, and no offset changes while `settled` is low or a strobe is present.
- R7: After a strobe, `settled` returns high one cycle after `settle_len` further valid samples have been counted. A new strobe restarts the count. With `settle_len` = 0, `settled` is low for exactly one cycle.
- R8: Each update stores `temp_tag` and `gain_sel` into the updated state's tag. `tag_temp`/`tag_gain` show the tag of the current `gain_sel`.
- R9: Every 4 updates of the active state, `drift_i`/`drift_q` take |offset now − offset at window start|, and `drift_alarm` goes high if either exceeds `drift_limit`. A change of `gain_sel` clears drift and alarm and restarts the window from the new state's offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample qualifier |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| gain_sel | input | 3 | Current gain-state index |
| gain_switch | input | 1 | Gain change in progress strobe |
| temp_tag | input | 8 | Temperature tag recorded on update |
| shift_k | input | 5 | Leak shift, clamped to 4..16 |
| settle_len | input | 16 | Valid samples to wait after a strobe |
| drift_limit | input | 16 | Drift alarm threshold |
| out_valid | output | 1 | Corrected sample qualifier |
| out_i | output | 16 | Corrected in-phase sample |
| out_q | output | 16 | Corrected quadrature sample |
| off_i | output | 16 | Active I offset |
| off_q | output | 16 | Active Q offset |
| tag_gain | output | 3 | Gain tag of active state |
| tag_temp | output | 8 | Temperature tag of active state |
| settled | output | 1 | High: learning allowed; low: held |
| drift_i | output | 16 | Last I drift magnitude |
| drift_q | output | 16 | Last Q drift magnitude |
| drift_alarm | output | 1 | Drift above threshold |

## Verification
The bench uses a second strobe inside the settle window. A design that fails to restart the count would report settled early and start learning on transients. It also checks a zero settle length, where an off-by-one design would either never drop the flag or hold it low for two cycles. It switches the gain index without a strobe and with no learning. A design that shares one estimate, or that zeroes the new state, would output the wrong corrected value on the first sample. It drives saturating offsets against full-scale inputs, where a wrapping subtractor flips the sign. It drives shift values outside the legal range, where a missing clamp gives a different offset after the first update.

// File: rtl/dc_offset_trim_pkg.sv
// Shared types and helpers for the DC offset trimmer.
// Assumes shift values arrive as 5-bit unsigned fields.
package dc_offset_trim_pkg;

    localparam int unsigned SHIFT_MIN = 4;
    localparam int unsigned SHIFT_MAX = 16;

    typedef enum logic {
        SETL_OK   = 1'b0,
        SETL_WAIT = 1'b1
    } settle_e;

    // Clamp a requested leak shift into the supported range.
    function automatic logic [4:0] clamp_shift(input logic [4:0] k);
        if (k < 5'(SHIFT_MIN))      return 5'(SHIFT_MIN);
        else if (k > 5'(SHIFT_MAX)) return 5'(SHIFT_MAX);
        else                        return k;
    endfunction

endpackage

// File: rtl/dc_offset_trim_settle.sv
// Freeze / settle sequencer. A strobe enters the hold state and loads the
// settle count; each later valid sample counts down; at zero the next cycle
// returns to the settled state. Assumes settle_len is stable while counting.
module dc_offset_trim_settle
    import dc_offset_trim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             gain_switch,
    input  logic [CNT_W-1:0] settle_len,
    output logic             settled
);

    settle_e          state;
    logic [CNT_W-1:0] remain;

    // Sequence hold and release around each gain switch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SETL_OK;
            remain <= '0;
        end else if (gain_switch) begin
            state  <= SETL_WAIT;
            remain <= settle_len;
        end else if (state == SETL_WAIT) begin
            if (remain == '0)  state  <= SETL_OK;
            else if (in_valid) remain <= remain - 1'b1;
        end
    end

    assign settled = (state == SETL_OK);

endmodule

// File: rtl/dc_offset_trim_bank.sv
// Per-gain-state offset storage with block averaging and leaky update.
// Learning samples are summed in blocks of 2**BLK_LOG2; each full block
// moves the selected state's accumulator by (mean - acc) >>> k.
// Assumes BLK_LOG2 >= 1 and FRAC_W >= the largest clamped shift.
module dc_offset_trim_bank
    import dc_offset_trim_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int FRAC_W   = 16,
    parameter int N_STATES = 8,
    parameter int TEMP_W   = 8,
    parameter int BLK_LOG2 = 2,
    localparam int ST_W    = $clog2(N_STATES),
    localparam int AW      = DATA_W + FRAC_W,
    localparam int SW      = DATA_W + BLK_LOG2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     freeze,
    input  logic                     sel_chg,
    input  logic [ST_W-1:0]          sel,
    input  logic signed [DATA_W-1:0] x_i,
    input  logic signed [DATA_W-1:0] x_q,
    input  logic [4:0]               shift_k,
    input  logic [TEMP_W-1:0]        temp_tag,
    output logic signed [DATA_W-1:0] off_i,
    output logic signed [DATA_W-1:0] off_q,
    output logic [ST_W-1:0]          tag_gain,
    output logic [TEMP_W-1:0]        tag_temp,
    output logic                     upd,
    output logic signed [DATA_W-1:0] new_off_i,
    output logic signed [DATA_W-1:0] new_off_q
);

    logic signed [AW-1:0]   acc_i [N_STATES];
    logic signed [AW-1:0]   acc_q [N_STATES];
    logic [TEMP_W-1:0]      tg_temp [N_STATES];
    logic [ST_W-1:0]        tg_gain [N_STATES];
    logic [BLK_LOG2-1:0]    cnt, base_cnt;
    logic signed [SW-1:0]   sum_i, sum_q, base_i, base_q, tot_i, tot_q;
    logic signed [DATA_W-1:0] mean_i, mean_q;
    logic signed [AW-1:0]   nxt_i, nxt_q;
    logic [4:0]             k_eff;
    logic                   last;

    // One leaky step of the accumulator toward the block mean.
    function automatic logic signed [AW-1:0] leak(
        input logic signed [AW-1:0]     acc,
        input logic signed [DATA_W-1:0] m,
        input logic [4:0]               k
    );
        logic signed [AW:0] tgt, dif;
        tgt = {m[DATA_W-1], m, {FRAC_W{1'b0}}};
        dif = tgt - {acc[AW-1], acc};
        dif = dif >>> k;
        return acc + dif[AW-1:0];
    endfunction

    // Block bookkeeping and next accumulator values.
    always_comb begin
        k_eff    = clamp_shift(shift_k);
        base_cnt = sel_chg ? '0 : cnt;
        base_i   = sel_chg ? '0 : sum_i;
        base_q   = sel_chg ? '0 : sum_q;
        tot_i    = base_i + SW'(x_i);
        tot_q    = base_q + SW'(x_q);
        mean_i   = DATA_W'(tot_i >>> BLK_LOG2);
        mean_q   = DATA_W'(tot_q >>> BLK_LOG2);
        last     = (base_cnt == BLK_LOG2'((1 << BLK_LOG2) - 1));
        upd      = in_valid && !freeze && last;
        nxt_i    = leak(acc_i[sel], mean_i, k_eff);
        nxt_q    = leak(acc_q[sel], mean_q, k_eff);
    end

    // Collect learning samples into blocks; discard on freeze or state change.
    always_ff @(posedge clk) begin
        if (!rst_n || freeze) begin
            cnt   <= '0;
            sum_i <= '0;
            sum_q <= '0;
        end else if (in_valid) begin
            if (last) begin
                cnt   <= '0;
                sum_i <= '0;
                sum_q <= '0;
            end else begin
                cnt   <= base_cnt + 1'b1;
                sum_i <= tot_i;
                sum_q <= tot_q;
            end
        end else if (sel_chg) begin
            cnt   <= '0;
            sum_i <= '0;
            sum_q <= '0;
        end
    end

    for (genvar s = 0; s < N_STATES; s++) begin : g_state
        // Hold one state's accumulators and tags; write on its update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_i[s]   <= '0;
                acc_q[s]   <= '0;
                tg_temp[s] <= '0;
                tg_gain[s] <= '0;
            end else if (upd && sel == ST_W'(s)) begin
                acc_i[s]   <= nxt_i;
                acc_q[s]   <= nxt_q;
                tg_temp[s] <= temp_tag;
                tg_gain[s] <= sel;
            end
        end
    end

    assign off_i     = acc_i[sel][AW-1:FRAC_W];
    assign off_q     = acc_q[sel][AW-1:FRAC_W];
    assign new_off_i = nxt_i[AW-1:FRAC_W];
    assign new_off_q = nxt_q[AW-1:FRAC_W];
    assign tag_temp  = tg_temp[sel];
    assign tag_gain  = tg_gain[sel];

endmodule

// File: rtl/dc_offset_trim_drift.sv
// Drift monitor for the active gain state. Counts updates in windows of
// 2**WIN_LOG2, reports the offset change over each window and compares it
// with a threshold. Assumes WIN_LOG2 >= 1 so a state change never meets a
// window end in the same cycle.
module dc_offset_trim_drift #(
    parameter int DATA_W   = 16,
    parameter int WIN_LOG2 = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  logic                     sel_chg,
    input  logic signed [DATA_W-1:0] cur_i,
    input  logic signed [DATA_W-1:0] cur_q,
    input  logic signed [DATA_W-1:0] new_i,
    input  logic signed [DATA_W-1:0] new_q,
    input  logic [DATA_W-1:0]        limit,
    output logic [DATA_W-1:0]        drift_i,
    output logic [DATA_W-1:0]        drift_q,
    output logic                     alarm
);

    logic [WIN_LOG2-1:0]      win, base_win;
    logic signed [DATA_W-1:0] snap_i, snap_q, bsnap_i, bsnap_q;
    logic [DATA_W-1:0]        mag_i, mag_q;

    // Magnitude of a signed difference, always representable unsigned.
    function automatic logic [DATA_W-1:0] absdiff(
        input logic signed [DATA_W-1:0] a,
        input logic signed [DATA_W-1:0] b
    );
        logic signed [DATA_W:0] d;
        d = {a[DATA_W-1], a} - {b[DATA_W-1], b};
        if (d[DATA_W]) d = -d;
        return d[DATA_W-1:0];
    endfunction

    // Window base values, restarted from the new state's offset on a change.
    always_comb begin
        base_win = sel_chg ? '0 : win;
        bsnap_i  = sel_chg ? cur_i : snap_i;
        bsnap_q  = sel_chg ? cur_q : snap_q;
        mag_i    = absdiff(new_i, bsnap_i);
        mag_q    = absdiff(new_q, bsnap_q);
    end

    // Advance the window and publish drift at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win     <= '0;
            snap_i  <= '0;
            snap_q  <= '0;
            drift_i <= '0;
            drift_q <= '0;
            alarm   <= 1'b0;
        end else if (upd) begin
            if (base_win == WIN_LOG2'((1 << WIN_LOG2) - 1)) begin
                win     <= '0;
                snap_i  <= new_i;
                snap_q  <= new_q;
                drift_i <= mag_i;
                drift_q <= mag_q;
                alarm   <= (mag_i > limit) || (mag_q > limit);
            end else begin
                win    <= base_win + 1'b1;
                snap_i <= bsnap_i;
                snap_q <= bsnap_q;
                if (sel_chg) begin
                    drift_i <= '0;
                    drift_q <= '0;
                    alarm   <= 1'b0;
                end
            end
        end else if (sel_chg) begin
            win     <= '0;
            snap_i  <= cur_i;
            snap_q  <= cur_q;
            drift_i <= '0;
            drift_q <= '0;
            alarm   <= 1'b0;
        end
    end

endmodule

// File: rtl/dc_offset_trim.sv
// Gain-state-aware DC offset trimmer: subtracts the active state's offsets
// from each I/Q sample with saturation, learns offsets in the background
// only while settled, and reports tags, settle status and drift.
// Assumes gain_sel is valid (< N_STATES) and samples are two's complement.
module dc_offset_trim #(
    parameter int DATA_W    = 16,
    parameter int N_STATES  = 8,
    parameter int TEMP_W    = 8,
    parameter int CNT_W     = 16,
    parameter int FRAC_W    = 16,
    parameter int BLK_LOG2  = 2,
    parameter int WIN_LOG2  = 2,
    localparam int ST_W     = $clog2(N_STATES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic [ST_W-1:0]          gain_sel,
    input  logic                     gain_switch,
    input  logic [TEMP_W-1:0]        temp_tag,
    input  logic [4:0]               shift_k,
    input  logic [CNT_W-1:0]         settle_len,
    input  logic [DATA_W-1:0]        drift_limit,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q,
    output logic signed [DATA_W-1:0] off_i,
    output logic signed [DATA_W-1:0] off_q,
    output logic [ST_W-1:0]          tag_gain,
    output logic [TEMP_W-1:0]        tag_temp,
    output logic                     settled,
    output logic [DATA_W-1:0]        drift_i,
    output logic [DATA_W-1:0]        drift_q,
    output logic                     drift_alarm
);

    localparam logic signed [DATA_W:0] POS_LIM = (DATA_W+1)'((1 << (DATA_W-1)) - 1);
    localparam logic signed [DATA_W:0] NEG_LIM = -(DATA_W+1)'(1 << (DATA_W-1));

    logic [ST_W-1:0]          prev_sel;
    logic                     sel_chg, freeze, upd;
    logic signed [DATA_W-1:0] new_i, new_q;

    // Subtract with clamping to the signed output range.
    function automatic logic signed [DATA_W-1:0] sub_sat(
        input logic signed [DATA_W-1:0] a,
        input logic signed [DATA_W-1:0] b
    );
        logic signed [DATA_W:0] d;
        d = {a[DATA_W-1], a} - {b[DATA_W-1], b};
        if (d > POS_LIM)      return POS_LIM[DATA_W-1:0];
        else if (d < NEG_LIM) return NEG_LIM[DATA_W-1:0];
        else                  return d[DATA_W-1:0];
    endfunction

    assign sel_chg = (gain_sel != prev_sel);
    assign freeze  = !settled || gain_switch;

    // Remember the previous gain index to detect state changes.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_sel <= '0;
        else        prev_sel <= gain_sel;
    end

    dc_offset_trim_settle #(.CNT_W(CNT_W)) u_settle (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .gain_switch (gain_switch),
        .settle_len  (settle_len),
        .settled     (settled)
    );

    dc_offset_trim_bank #(
        .DATA_W   (DATA_W),
        .FRAC_W   (FRAC_W),
        .N_STATES (N_STATES),
        .TEMP_W   (TEMP_W),
        .BLK_LOG2 (BLK_LOG2)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .freeze    (freeze),
        .sel_chg   (sel_chg),
        .sel       (gain_sel),
        .x_i       (in_i),
        .x_q       (in_q),
        .shift_k   (shift_k),
        .temp_tag  (temp_tag),
        .off_i     (off_i),
        .off_q     (off_q),
        .tag_gain  (tag_gain),
        .tag_temp  (tag_temp),
        .upd       (upd),
        .new_off_i (new_i),
        .new_off_q (new_q)
    );

    dc_offset_trim_drift #(
        .DATA_W   (DATA_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_drift (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .sel_chg (sel_chg),
        .cur_i   (off_i),
        .cur_q   (off_q),
        .new_i   (new_i),
        .new_q   (new_q),
        .limit   (drift_limit),
        .drift_i (drift_i),
        .drift_q (drift_q),
        .alarm   (drift_alarm)
    );

    // Register the corrected sample with the active state's offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= sub_sat(in_i, off_i);
                out_q <= sub_sat(in_q, off_q);
            end
        end
    end

endmodule

// File: rtl/dc_offset_trim_chk.sv
// Property checker for dc_offset_trim, attached by bind below.
// Assumes synchronous active-low reset.
module dc_offset_trim_chk #(
    parameter int DATA_W = 16,
    parameter int ST_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_i,
    input logic [ST_W-1:0]          gain_sel,
    input logic                     gain_switch,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_i,
    input logic signed [DATA_W-1:0] off_i,
    input logic                     settled
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_i[DATA_W-1] && off_i[DATA_W-1]) |=> !out_i[DATA_W-1]); // R3
    AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_i[DATA_W-1] && !off_i[DATA_W-1] && off_i != '0) |=> out_i[DATA_W-1]); // R3
    AST_HOLD_WHILE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!settled || gain_switch) |=> (off_i == $past(off_i) || gain_sel != $past(gain_sel))); // R6
    AST_STROBE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        gain_switch |=> !settled); // R6
    AST_SETTLED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !gain_switch) |=> settled); // R7

endmodule

bind dc_offset_trim dc_offset_trim_chk #(.DATA_W(DATA_W), .ST_W(ST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_i        (in_i),
    .gain_sel    (gain_sel),
    .gain_switch (gain_switch),
    .out_valid   (out_valid),
    .out_i       (out_i),
    .off_i       (off_i),
    .settled     (settled)
);

// File: tb/dc_offset_trim_tb.sv
// Directed bench for dc_offset_trim with an independent reference model.
module dc_offset_trim_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic [2:0]  gain_sel = '0;
    logic        gain_switch = 1'b0;
    logic [7:0]  temp_tag = '0;
    logic [4:0]  shift_k = 5'd4;
    logic [15:0] settle_len = '0;
    logic [15:0] drift_limit = 16'hFFFF;
    logic        out_valid, settled, drift_alarm;
    logic signed [15:0] out_i, out_q, off_i, off_q;
    logic [2:0]  tag_gain;
    logic [7:0]  tag_temp;
    logic [15:0] drift_i, drift_q;

    int total = 0;
    int bad = 0;

    // Reference model state
    longint accm [8][2];
    int     tgt_m [8];
    int     tgg_m [8];
    longint sum_m [2];
    int     cnt_m, prev_m, rem_m, win_m;
    bit     set_m, alm_m;
    int     snap_m [2];
    int     drf_m [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_offset_trim u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .gain_sel(gain_sel), .gain_switch(gain_switch), .temp_tag(temp_tag),
        .shift_k(shift_k), .settle_len(settle_len), .drift_limit(drift_limit),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .off_i(off_i), .off_q(off_q),
        .tag_gain(tag_gain), .tag_temp(tag_temp), .settled(settled),
        .drift_i(drift_i), .drift_q(drift_q), .drift_alarm(drift_alarm)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int offm(int s, int c);
        return int'(accm[s][c] >>> 16);
    endfunction

    function automatic int satf(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int kclamp(int k);
        if (k < 4) return 4;
        if (k > 16) return 16;
        return k;
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 8; s++) begin
            accm[s][0] = 0; accm[s][1] = 0; tgt_m[s] = 0; tgg_m[s] = 0;
        end
        sum_m[0] = 0; sum_m[1] = 0; cnt_m = 0; prev_m = 0; rem_m = 0; win_m = 0;
        set_m = 1; alm_m = 0; snap_m[0] = 0; snap_m[1] = 0; drf_m[0] = 0; drf_m[1] = 0;
    endtask

    // Drive one cycle, advance the model, and compare all per-cycle outputs.
    task automatic step(input bit v, input int xi, input int xq, input int sel,
                        input bit sw, input int tmp);
        int  x [2];
        int  eo [2];
        int  pre [2];
        int  nw [2];
        bit  chg, frz, upd;
        int  bw;
        longint mean;
        @(negedge clk);
        in_valid = v; in_i = 16'(xi); in_q = 16'(xq); gain_sel = 3'(sel);
        gain_switch = sw; temp_tag = 8'(tmp);
        x[0] = xi; x[1] = xq;
        chg = (sel != prev_m);
        frz = !set_m || sw;
        upd = 0;
        for (int c = 0; c < 2; c++) begin
            pre[c] = offm(sel, c);
            eo[c]  = satf(x[c] - pre[c]);
        end
        if (chg) begin cnt_m = 0; sum_m[0] = 0; sum_m[1] = 0; end
        if (frz) begin
            cnt_m = 0; sum_m[0] = 0; sum_m[1] = 0;
        end else if (v) begin
            if (cnt_m == 3) begin
                upd = 1;
                for (int c = 0; c < 2; c++) begin
                    mean = (sum_m[c] + x[c]) >>> 2;
                    accm[sel][c] = accm[sel][c] + (((mean <<< 16) - accm[sel][c]) >>> kclamp(int'(shift_k)));
                    nw[c] = offm(sel, c);
                end
                tgt_m[sel] = tmp; tgg_m[sel] = sel;
                cnt_m = 0; sum_m[0] = 0; sum_m[1] = 0;
            end else begin
                cnt_m++; sum_m[0] += x[0]; sum_m[1] += x[1];
            end
        end
        bw = chg ? 0 : win_m;
        if (chg) begin snap_m[0] = pre[0]; snap_m[1] = pre[1]; end
        if (upd) begin
            if (bw == 3) begin
                drf_m[0] = iabs(nw[0] - snap_m[0]);
                drf_m[1] = iabs(nw[1] - snap_m[1]);
                alm_m = (drf_m[0] > int'(drift_limit)) || (drf_m[1] > int'(drift_limit));
                snap_m[0] = nw[0]; snap_m[1] = nw[1]; win_m = 0;
            end else begin
                win_m = bw + 1;
                if (chg) begin drf_m[0] = 0; drf_m[1] = 0; alm_m = 0; end
            end
        end else if (chg) begin
            win_m = 0; drf_m[0] = 0; drf_m[1] = 0; alm_m = 0;
        end
        if (sw) begin
            set_m = 0; rem_m = int'(settle_len);
        end else if (!set_m) begin
            if (rem_m == 0) set_m = 1;
            else if (v) rem_m--;
        end
        prev_m = sel;
        @(posedge clk); #1;
        chk("R2 out_valid", out_valid, v);
        if (v) begin
            chk("R2 out_i", out_i, eo[0]);
            chk("R2 out_q", out_q, eo[1]);
        end
        chk("R7 settled", settled, set_m);
        chk("R5 off_i", off_i, offm(sel, 0));
        chk("R5 off_q", off_q, offm(sel, 1));
        chk("R9 drift_i", drift_i, drf_m[0]);
        chk("R9 drift_q", drift_q, drf_m[1]);
        chk("R9 alarm", drift_alarm, alm_m);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        model_reset();
        #1;
        chk("R1 out_valid", out_valid, 0);
        chk("R1 out_i", out_i, 0);
        chk("R1 settled", settled, 1);
        chk("R1 off_i", off_i, 0);
        chk("R1 tag_temp", tag_temp, 0);
        chk("R1 drift_alarm", drift_alarm, 0);
    endtask

    task automatic t_learn_basic();
        shift_k = 5'd4;
        for (int n = 0; n < 8; n++) step(1, 1000, -500, 0, 0, 33);
        chk("R5 off_i after two blocks", off_i, offm(0, 0));
        chk("R5 off_i nonzero", (off_i > 0), 1);
        step(0, 0, 0, 0, 0, 33);
        step(1, 1200, -400, 0, 0, 33);
    endtask

    task automatic t_per_state();
        int keep;
        keep = offm(0, 0);
        step(1, 300, 300, 3, 0, 0);
        chk("R4 new state uses own zero offset", out_i, 300);
        for (int n = 0; n < 4; n++) step(1, -2000, 700, 3, 0, 10);
        step(1, 500, 500, 0, 0, 0);
        chk("R4 state 0 offset kept", off_i, keep);
        chk("R4 state 0 applied at once", out_i, 500 - keep);
    endtask

    task automatic t_freeze_settle();
        int hold;
        settle_len = 16'd5;
        hold = offm(0, 0);
        step(1, 100, 100, 0, 1, 0);
        chk("R6 settled low after strobe", settled, 0);
        for (int n = 0; n < 3; n++) step(1, 20000, 20000, 0, 0, 0);
        step(1, 20000, 20000, 0, 1, 0);
        for (int n = 0; n < 5; n++) step(1, 20000, 20000, 0, 0, 0);
        chk("R7 still held after restart", settled, 0);
        chk("R6 offset unchanged while held", off_i, hold);
        step(0, 0, 0, 0, 0, 0);
        chk("R7 released after count", settled, 1);
        settle_len = 16'd0;
        step(0, 0, 0, 0, 1, 0);
        chk("R7 zero length low", settled, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R7 zero length release", settled, 1);
    endtask

    task automatic t_saturate();
        shift_k = 5'd4;
        for (int n = 0; n < 120; n++) step(1, -32768, 32767, 5, 0, 0);
        step(1, 32767, -32768, 5, 0, 0);
        chk("R3 clamp high", out_i, 32767);
        chk("R3 clamp low", out_q, -32768);
    endtask

    task automatic t_shift_clamp();
        shift_k = 5'd0;
        for (int n = 0; n < 4; n++) step(1, 1600, 1600, 7, 0, 0);
        chk("R5 shift 0 acts as 4", off_i, 100);
        shift_k = 5'd31;
        for (int n = 0; n < 4; n++) step(1, 32000, 0, 2, 0, 0);
        chk("R5 shift 31 acts as 16", off_i, 0);
        shift_k = 5'd4;
    endtask

    task automatic t_tags();
        for (int n = 0; n < 4; n++) step(1, 64, 64, 1, 0, 8'h5A);
        chk("R8 tag_temp", tag_temp, 8'h5A);
        chk("R8 tag_gain", tag_gain, 1);
        step(0, 0, 0, 4, 0, 8'h11);
        chk("R8 untouched state tag", tag_temp, 0);
    endtask

    task automatic t_drift();
        drift_limit = 16'd50;
        for (int n = 0; n < 16; n++) step(1, 4000, -4000, 6, 0, 0);
        chk("R9 drift nonzero", (drift_i > 0), 1);
        chk("R9 alarm above limit", drift_alarm, 1);
        drift_limit = 16'hFFFF;
        for (int n = 0; n < 16; n++) step(1, 4000, -4000, 6, 0, 0);
        chk("R9 alarm below limit", drift_alarm, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R9 cleared on state change", drift_i, 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_learn_basic();
        t_per_state();
        t_freeze_settle();
        t_saturate();
        t_shift_clamp();
        t_tags();
        t_drift();
        summary();
        $finish;
    end

endmodule